// File: doc/BRIEF.md
# Read-Triggered Sampling Converter Register Block

This block is the register-side controller for an eight-way multiplexed sampling converter. Software reads a result register to start a conversion. After a fixed number of module-clock periods the block latches the converter's 16-bit sample. It then raises a ready flag in bit 31 of the result word. The next read of the result register returns that word and starts the following conversion. The analog converter itself is modelled by the `sample_in` port, which is captured in the cycle the conversion completes.

The input multiplexer is steered by a switch configuration register that drives `sw_cfg`. That register is protected: a write to it is accepted only when the bus write just before it put the key value into a separate lock register. After every accepted switch change, a settling interval must elapse before any conversion may complete. The module clock comes from a prescaler that divides the bus clock by 4 or by 16, as chosen by `div_slow`. The settling interval has its own tick count for each divisor. Every timing value is a count of module ticks set by a parameter, so shortened timings can be used.

There is no data stream at this block's edge. The bus is a plain register interface with no back-pressure: a write completes in the cycle `bus_wr` is high, and a read returns data combinationally in the cycle `bus_rd` is high.

Top module: `adc_regif`

## Requirements
- R1: After reset `sw_cfg` is 0, the stored result word is 0 (ready flag clear, data 0), and `bus_rdata` is 0 in any cycle without `bus_rd`.
- R2: A read of offset 0x08 returns the ready flag in bit 31, copies of sample bit 15 in bits 30..16, and the sample in bits 15..0. A read of 0x18 returns the switch value in bits 11..0 with zeros above. Offset 0x20 and every other offset read as 0.
- R3: A write to offset 0x18 loads `wdata[11:0]` into `sw_cfg` only when the previous bus write wrote exactly 0x000000AA to offset 0x20. Channel codes such as 0x608 and 0x680 pass through unchanged.
- R4: Any bus write other than the key write closes the gate, and an accepted switch write consumes the key. A second switch write without a new key is therefore ignored.
- R5: A switch write made while the gate is closed leaves `sw_cfg` unchanged.
- R6: A read of 0x08 returns the word held before that read, starts a conversion, and clears the ready flag from the next cycle on.
- R7: A conversion completes once CONV_TICKS module ticks have passed since its trigger. In the completion cycle `sample_in` is captured and the ready flag is set.
- R8: A trigger read during a conversion restarts the tick count. Only one completion follows.
- R9: An accepted switch write loads a settling count of SETTLE_FAST ticks (`div_slow`=0) or SETTLE_SLOW ticks (`div_slow`=1). No conversion completes while that count is nonzero.
- R10: The module tick occurs once every 4 bus clocks when `div_slow`=0 and once every 16 when `div_slow`=1. Two ticks never fall in adjacent cycles.
- R11: When a trigger read falls in the same cycle as a completion, the trigger wins: a new conversion starts and the ready flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read of 0x08 is a conversion trigger |
| bus_rdata | output | 32 | Combinational read data |
| div_slow | input | 1 | 0: module clock = clk/4, 1: clk/16 |
| sample_in | input | 16 | Converter sample, two's complement |
| sw_cfg | output | 12 | Analog switch configuration |

## Verification
Two functions can meet in the same cycle. A trigger read can land on the cycle in which a running conversion would complete. A switch write can arrive in the middle of a conversion and hold its completion back. The bench provokes the first case by repeating trigger-then-read pairs while sweeping the gap between them across every cycle offset. It provokes the second by writing the switch register just after a trigger. A behavioural reference model, updated on every clock, judges each cycle by comparing the read data and the switch output against it.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam logic [7:0]  OFF_RESULT = 8'h08;
  localparam logic [7:0]  OFF_SWITCH = 8'h18;
  localparam logic [7:0]  OFF_LOCK   = 8'h20;
  localparam logic [31:0] LOCK_KEY   = 32'h0000_00AA;
  localparam int SW_W   = 12;
  localparam int DATA_W = 16;

  // ready flag on top, sign copies between, sample at the bottom
  function automatic logic [31:0] pack_result(input logic rdy, input logic [DATA_W-1:0] d);
    return {rdy, {(31-DATA_W){d[DATA_W-1]}}, d};
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_slow,
  output logic tick
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = div_slow ? LIM_SLOW : LIM_FAST;
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R10: a tick is never followed by another in the next cycle
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/adc_switch_gate.sv
module adc_switch_gate
  import adc_regif_pkg::*;
#(
  parameter int SETTLE_FAST = 256,
  parameter int SETTLE_SLOW = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  input  logic            tick,
  input  logic            div_slow,
  output logic [SW_W-1:0] sw_cfg,
  output logic            settle_done
);
  localparam int SMAX = (SETTLE_FAST > SETTLE_SLOW) ? SETTLE_FAST : SETTLE_SLOW;
  localparam int SW2  = $clog2(SMAX + 1);
  localparam logic [SW2-1:0] LOAD_FAST = SW2'(SETTLE_FAST);
  localparam logic [SW2-1:0] LOAD_SLOW = SW2'(SETTLE_SLOW);

  logic           gate_open;
  logic           accept;
  logic           locked_try;
  logic [SW2-1:0] settle_cnt;

  assign accept      = wr && (addr == OFF_SWITCH) && gate_open;
  assign locked_try  = wr && (addr == OFF_SWITCH) && !gate_open;
  assign settle_done = (settle_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)  gate_open <= 1'b0;
    else if (wr) gate_open <= (addr == OFF_LOCK) && (wdata == LOCK_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sw_cfg <= '0;
    else if (accept) sw_cfg <= wdata[SW_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   settle_cnt <= '0;
    else if (accept)              settle_cnt <= div_slow ? LOAD_SLOW : LOAD_FAST;
    else if (tick && !settle_done) settle_cnt <= settle_cnt - 1'b1;
  end

  // R5: a switch write with the gate closed leaves the register alone
  a_r5_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    locked_try |=> $stable(sw_cfg));
  // R4: an accepted write consumes the key
  a_r4_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gate_open);
  // R9: an accepted write always leaves a pending settle interval
  a_r9_settle_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !settle_done);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_regif_pkg::*;
#(
  parameter int CONV_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic              tick,
  input  logic              settle_done,
  input  logic [DATA_W-1:0] sample_in,
  output logic              ready,
  output logic [DATA_W-1:0] data
);
  localparam int CW = $clog2(CONV_TICKS + 1);
  localparam logic [CW-1:0] CONV_LOAD = CW'(CONV_TICKS);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          finish;

  assign finish = busy && (cnt == '0) && settle_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ready <= 1'b0;
      data  <= '0;
    end else if (trigger) begin
      busy  <= 1'b1;
      cnt   <= CONV_LOAD;
      ready <= 1'b0;
    end else if (finish) begin
      busy  <= 1'b0;
      ready <= 1'b1;
      data  <= sample_in;
    end else if (busy && tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R6 / R11: a trigger always leaves the ready flag clear afterwards
  a_r6_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !ready);
  // R9: ready only rises when settling had elapsed
  a_r9_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(settle_done));
  // R7: captured data only changes when ready rises
  a_r7_data_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> $rose(ready));
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int FAST_DIV    = 4,
  parameter int SLOW_DIV    = 16,
  parameter int CONV_TICKS  = 16,
  parameter int SETTLE_FAST = 256,
  parameter int SETTLE_SLOW = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        div_slow,
  input  logic [15:0] sample_in,
  output logic [11:0] sw_cfg
);
  logic              tick;
  logic              settle_done;
  logic              trigger;
  logic              ready;
  logic [DATA_W-1:0] data;

  assign trigger = bus_rd && (bus_addr == OFF_RESULT);

  adc_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_slow(div_slow), .tick(tick));

  adc_switch_gate #(.SETTLE_FAST(SETTLE_FAST), .SETTLE_SLOW(SETTLE_SLOW)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tick(tick), .div_slow(div_slow), .sw_cfg(sw_cfg), .settle_done(settle_done));

  adc_conv_ctrl #(.CONV_TICKS(CONV_TICKS)) u_conv (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .tick(tick),
    .settle_done(settle_done), .sample_in(sample_in), .ready(ready), .data(data));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFF_RESULT: bus_rdata = pack_result(ready, data);
        OFF_SWITCH: bus_rdata = {{(32-SW_W){1'b0}}, sw_cfg};
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R2: the sign field always agrees with sample bit 15
  a_r2_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> (bus_rdata[30:16] == {15{bus_rdata[15]}}));
  // R1: idle bus reads zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'h0));
endmodule

// File: tb/test_adc_regif.sv
module test_adc_regif;
  localparam int CONV = 3, SF = 4, SS = 2;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0, div_slow = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] sample_in = 0;
  logic [11:0] sw_cfg;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  bit   vary = 1;

  // behavioural reference state
  int m_pc, m_settle, m_cnt, m_sw;
  bit m_gate, m_busy, m_ready;
  int m_data;

  always #4 clk = ~clk;

  adc_regif #(.FAST_DIV(4), .SLOW_DIV(16), .CONV_TICKS(CONV),
              .SETTLE_FAST(SF), .SETTLE_SLOW(SS)) i_adc_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .div_slow(div_slow), .sample_in(sample_in), .sw_cfg(sw_cfg));

  always @(posedge clk) begin
    bit tk, trig, acc;
    if (!rst_n) begin
      m_pc = 0; m_settle = 0; m_cnt = 0; m_sw = 0;
      m_gate = 0; m_busy = 0; m_ready = 0; m_data = 0;
    end else begin
      tk   = m_pc >= (div_slow ? 15 : 3);
      trig = bus_rd && bus_addr == 8'h08;
      acc  = bus_wr && bus_addr == 8'h18 && m_gate;
      if (trig) begin m_busy = 1; m_cnt = CONV; m_ready = 0; end
      else if (m_busy && m_cnt == 0 && m_settle == 0) begin
        m_busy = 0; m_ready = 1; m_data = sample_in;
      end else if (m_busy && tk && m_cnt > 0) m_cnt--;
      if (acc) m_settle = div_slow ? SS : SF;
      else if (tk && m_settle > 0) m_settle--;
      if (acc) m_sw = bus_wdata[11:0];
      if (bus_wr) m_gate = (bus_addr == 8'h20 && bus_wdata == 32'hAA);
      m_pc = tk ? 0 : m_pc + 1;
    end
  end

  function automatic logic [31:0] model_rdata();
    if (!bus_rd) return 0;
    if (bus_addr == 8'h08)
      return {m_ready, {15{m_data[15]}}, m_data[15:0]};
    if (bus_addr == 8'h18) return {20'h0, m_sw[11:0]};
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (vary) sample_in <= 16'((cyc * 7919) % 50001 - 25000);
    #2;
    if (rst_n) begin
      check({cur_req, " rdata"}, bus_rdata, model_rdata());
      check({cur_req, " sw_cfg"}, {20'h0, sw_cfg}, 32'(m_sw));
    end
  end

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1;
    // R1: reset state
    cur_req = "R1";
    idle(2);
    check("R1 sw_cfg", {20'h0, sw_cfg}, 32'h0);
    check("R1 idle rdata", bus_rdata, 32'h0);
    rd(8'h20, v); check("R2 lock reads 0", v, 32'h0);

    // R3: keyed write accepted
    cur_req = "R3";
    wr(8'h20, 32'hAA); wr(8'h18, 32'h680);
    idle(1); check("R3 code 0x680", {20'h0, sw_cfg}, 32'h680);
    rd(8'h18, v); check("R2 switch readback", v, 32'h680);

    // R5: write without key ignored
    cur_req = "R5";
    wr(8'h18, 32'h608); idle(1);
    check("R5 locked write", {20'h0, sw_cfg}, 32'h680);
    // R4: interleaved write closes the gate; key consumed
    cur_req = "R4";
    wr(8'h20, 32'hAA); wr(8'h08, 32'h0); wr(8'h18, 32'h640); idle(1);
    check("R4 interleaved write", {20'h0, sw_cfg}, 32'h680);
    wr(8'h20, 32'h1AA); wr(8'h18, 32'h640); idle(1);
    check("R3 wrong key", {20'h0, sw_cfg}, 32'h680);
    wr(8'h20, 32'hAA); wr(8'h18, 32'h620); wr(8'h18, 32'h610); idle(1);
    check("R4 key consumed", {20'h0, sw_cfg}, 32'h620);

    // R6/R7/R2: conversion with fixed negative sample
    cur_req = "R7";
    vary = 0; sample_in = 16'h9E58; // -25000
    idle(40);
    rd(8'h08, v); check("R6 first read not ready", v[31], 1'b0);
    idle(30);
    rd(8'h08, v); check("R7 ready negative", v, 32'hFFFF9E58);
    sample_in = 16'h61A8; // +25000
    idle(30);
    rd(8'h08, v); check("R2 ready positive", v, 32'h800061A8);
    rd(8'h08, v); check("R6 read after trigger", v, 32'h000061A8);

    // R8: repeated triggers restart the count
    cur_req = "R8";
    vary = 1;
    repeat (6) begin rd(8'h08, v); idle(5); end
    idle(30); rd(8'h08, v); check("R8 single completion", v[31], 1'b1);

    // R9: switch write inside a conversion delays completion
    cur_req = "R9";
    rd(8'h08, v);
    wr(8'h20, 32'hAA); wr(8'h18, 32'h601);
    idle(14); rd(8'h08, v); check("R9 held by settling", v[31], 1'b0);
    idle(40); rd(8'h08, v); check("R9 completes later", v[31], 1'b1);

    // R11: sweep trigger-to-read gap over every cycle offset
    cur_req = "R11";
    for (int g = 0; g < 24; g++) begin
      rd(8'h08, v); idle(g);
    end
    idle(30);

    // R10: slow divisor
    cur_req = "R10";
    div_slow = 1;
    wr(8'h20, 32'hAA); wr(8'h18, 32'h604);
    rd(8'h08, v); idle(40);
    rd(8'h08, v); check("R10 slow not yet", v[31], 1'b0);
    idle(120);
    rd(8'h08, v); check("R10 slow done", v[31], 1'b1);
    for (int g = 0; g < 20; g++) begin
      rd(8'h08, v); idle(g * 3);
    end
    idle(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule